// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

This block is a 4-bit accumulator processor that keeps no program counter and no memory address of its own. External logic feeds it one nibble at a time on a shared input: an opcode in the first clock of each instruction and a data nibble after that. The core builds branch targets and memory addresses a nibble at a time. It hands them out on one 8-bit output that is shared in time, together with a set of request flags. The external logic acts on those flags by updating its address register, writing memory, loading its program counter, or fetching the next operand from program memory.

Every instruction takes exactly four clocks, T0 to T3, and the cadence never stalls. No back-pressure is possible: the external logic must follow the phase sequence. That sequence begins at T0 in the first clock after reset is released. A separate memory-mapped unit drives a per-instruction hit input. When that input is high, a store targets an on-chip location and no external write is requested.

Top module: `acc4_core`

## Requirements
- R1: While rst_n is low, all internal state clears: result register, carry, destination register, destination pointer, address buffer, request flags and phase. After release, the first clock is T0. A JZ issued first therefore branches with DB0 = 0x00 and DB1 = 0x40.
- R2: The opcode on bus_in is sampled at the end of T0 and the data nibble at the end of T1. bus_out is 0 during T0. During T1 it carries DB0, and during T2 and T3 it carries DB1, which holds steady across both clocks.
- R3: DB1 bit 4 is the MAR request, bit 5 WRITE, bit 6 JMP and bit 7 I, with bits 3:0 holding the result register. At most one of bits 7:4 is set.
- R4: LD (0000) loads the data nibble. OR (1100), AND (1101) and XOR (1110) combine the data nibble with the result register and leave the carry unchanged.
- R5: ADD (1000) and ADC (1010) add the data nibble to the result register; ADC also adds the carry. The carry becomes the bit above the 4-bit sum.
- R6: SUB (1001) subtracts the data nibble. SUC (1011) subtracts the data nibble plus the inverted carry. The carry is 1 when no borrow occurred and 0 on borrow.
- R7: STR (0001) raises WRITE, with the result register in DB1 bits 3:0. WRITE stays low when periph_hit is high during T1.
- R8: SEI (0010) raises I. I drops when the next instruction completes, unless that instruction is LDR (0111), in which case I stays set.
- R9: LDR writes the pointed-to destination nibble and steps the pointer through 0, 1, 2 and back to 0; nibble 0 is bits 3:0. The written value is the data nibble when I is set and the result register otherwise.
- R10: LML (0011) and LMH (1111) load the low or high address-buffer nibble, using the data nibble when I is set and the result register otherwise. Each shows the whole buffer as DB0 with MAR raised.
- R11: JMP (0100), JC (0101) when the carry is 1, and JZ (0110) when the result register is 0 raise JMP. For a taken jump, DB1 bits 3:0 carry destination bits 11:8. Jump opcodes show destination bits 7:0 as DB0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 4 | Opcode in T0, data nibble in T1 |
| periph_hit | input | 1 | Current access targets a memory-mapped location (sampled in T1) |
| bus_out | output | 8 | Zero in T0, DB0 in T1, DB1 in T2 and T3 |

## Verification
Directed sequences come first. They cover branches taken from reset state, loading the destination with I held across three LDRs and a fourth that wraps, carry chains through 0xF + 1, and borrows with both carry values. A long run of random opcodes, data and hit values follows. It mixes arithmetic with the immediate and jump paths, so the carry source, the I persistence and the destination pointer are all used in orders that no directed case reaches. Each instruction's DB0, both DB1 samples and the T0 zero are compared against a bench model. This separates a wrong data source, a wrong flag bit and a wrong phase.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int NW    = 4;
  localparam int BYTEW = 2 * NW;
  localparam int NPH   = 4;
  localparam int PHW   = $clog2(NPH);

  typedef enum logic [NW-1:0] {
    OP_LD  = 4'h0, OP_STR = 4'h1, OP_SEI = 4'h2, OP_LML = 4'h3,
    OP_JMP = 4'h4, OP_JC  = 4'h5, OP_JZ  = 4'h6, OP_LDR = 4'h7,
    OP_ADD = 4'h8, OP_SUB = 4'h9, OP_ADC = 4'hA, OP_SUC = 4'hB,
    OP_OR  = 4'hC, OP_AND = 4'hD, OP_XOR = 4'hE, OP_LMH = 4'hF
  } op_e;

  localparam logic [PHW-1:0] PH_T0 = 2'd0;
  localparam logic [PHW-1:0] PH_T1 = 2'd1;
  localparam logic [PHW-1:0] PH_T2 = 2'd2;
  localparam logic [PHW-1:0] PH_T3 = 2'd3;

  // packed MSB first: imm lands on output bit 7, mar on bit 4
  typedef struct packed {
    logic imm;
    logic jmp;
    logic wr;
    logic mar;
  } req_t;
endpackage

// File: rtl/acc4_phase.sv
module acc4_phase
  import acc4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  output logic [PHW-1:0] ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_T0;
    else if (ph == PHW'(NPH - 1)) ph <= PH_T0;
    else ph <= ph + 1'b1;
  end
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
(
  input  op_e           op,
  input  logic [NW-1:0] acc,
  input  logic          cin,
  input  logic [NW-1:0] din,
  output logic [NW-1:0] acc_n,
  output logic          cy_n
);
  logic [NW-1:0] opb;
  logic          c0;
  logic [NW:0]   sum;

  always_comb begin
    opb = din;
    c0  = 1'b0;
    unique case (op)
      OP_SUB:  begin opb = ~din; c0 = 1'b1; end
      OP_SUC:  begin opb = ~din; c0 = cin;  end
      OP_ADC:  c0 = cin;
      default: ;
    endcase
    sum = {1'b0, acc} + {1'b0, opb} + {{NW{1'b0}}, c0};
  end

  always_comb begin
    acc_n = acc;
    cy_n  = cin;
    unique case (op)
      OP_LD:  acc_n = din;
      OP_ADD, OP_SUB, OP_ADC, OP_SUC: begin
        acc_n = sum[NW-1:0];
        cy_n  = sum[NW];
      end
      OP_OR:  acc_n = acc | din;
      OP_AND: acc_n = acc & din;
      OP_XOR: acc_n = acc ^ din;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc4_dest.sv
module acc4_dest
  import acc4_pkg::*;
#(
  parameter int NIBS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NW-1:0]      din,
  output logic [NIBS*NW-1:0] tgt
);
  localparam int PW = $clog2(NIBS);
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (we) ptr <= (ptr == PW'(NIBS - 1)) ? '0 : ptr + 1'b1;
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt[g*NW +: NW] <= '0;
      else if (we && ptr == PW'(g)) tgt[g*NW +: NW] <= din;
    end
  end
endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc4_pkg::*;
#(
  parameter int TGT_NIBS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    bus_in,
  input  logic             periph_hit,
  output logic [BYTEW-1:0] bus_out
);
  localparam int TGT_W = TGT_NIBS * NW;

  logic [PHW-1:0]   ph;
  logic [NW-1:0]    ir;
  op_e              op;
  logic [NW-1:0]    rr, rr_n;
  logic             cy, cy_n;
  logic [BYTEW-1:0] mab, mab_n;
  logic [TGT_W-1:0] dr;
  req_t             req_q, req_n;
  logic             imm_q;
  logic             commit, is_jump, dr_we;
  logic [NW-1:0]    src;
  logic [BYTEW-1:0] db0, db1;

  acc4_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ph == PH_T0) ir <= bus_in;
  end

  assign op     = op_e'(ir);
  assign commit = (ph == PH_T1);
  assign imm_q  = req_q.imm;
  assign src    = imm_q ? bus_in : rr;

  acc4_alu u_alu (
    .op(op), .acc(rr), .cin(cy), .din(bus_in), .acc_n(rr_n), .cy_n(cy_n)
  );

  assign dr_we = commit && (op == OP_LDR);

  acc4_dest #(.NIBS(TGT_NIBS)) u_dest (
    .clk(clk), .rst_n(rst_n), .we(dr_we), .din(src), .tgt(dr)
  );

  always_comb begin
    mab_n = mab;
    if (op == OP_LML) mab_n[NW-1:0] = src;
    if (op == OP_LMH) mab_n[BYTEW-1:NW] = src;
  end

  always_comb begin
    is_jump   = (op == OP_JMP) || (op == OP_JC) || (op == OP_JZ);
    req_n     = '0;
    req_n.mar = (op == OP_LML) || (op == OP_LMH);
    req_n.wr  = (op == OP_STR) && !periph_hit;
    req_n.jmp = (op == OP_JMP) || (op == OP_JC && cy) ||
                (op == OP_JZ && rr == '0);
    req_n.imm = (op == OP_SEI) || (op == OP_LDR && imm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr    <= '0;
      cy    <= 1'b0;
      mab   <= '0;
      req_q <= '0;
    end else if (commit) begin
      rr    <= rr_n;
      cy    <= cy_n;
      mab   <= mab_n;
      req_q <= req_n;
    end
  end

  assign db0 = is_jump ? dr[BYTEW-1:0] : mab_n;
  assign db1 = {req_q, req_q.jmp ? dr[TGT_W-1 -: NW] : rr};

  always_comb begin
    unique case (ph)
      PH_T0:   bus_out = '0;
      PH_T1:   bus_out = db0;
      default: bus_out = db1;
    endcase
  end
endmodule

// File: rtl/acc4_core_chk.sv
module acc4_core_chk
  import acc4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [PHW-1:0]   ph,
  input logic [NW-1:0]    ir,
  input logic             cy,
  input logic             imm_q,
  input logic             periph_hit,
  input logic [BYTEW-1:0] bus_out
);
  p_t0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T0) |-> (bus_out == '0));

  p_db1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T3) |-> $stable(bus_out));

  p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T2 || ph == PH_T3) |-> $onehot0(bus_out[7:4]));

  p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1 && (ir == OP_OR || ir == OP_AND || ir == OP_XOR)) |=> $stable(cy));

  p_hit_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1 && periph_hit) |=> !bus_out[5]);

  p_ldr_keeps_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1 && ir == OP_LDR && imm_q) |=> bus_out[7]);

  p_addr_raises_mar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1 && (ir == OP_LML || ir == OP_LMH)) |=> bus_out[4]);
endmodule

bind acc4_core acc4_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .ir(ir), .cy(cy), .imm_q(imm_q),
  .periph_hit(periph_hit), .bus_out(bus_out)
);

// File: tb/acc4_core_bench.sv
module acc4_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_in = 4'h0;
  logic       periph_hit = 1'b0;
  logic [7:0] bus_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_rr = 0;
  logic        m_cy = 0;
  logic [11:0] m_dr = 0;
  int          m_ptr = 0;
  logic [7:0]  m_mab = 0;
  logic        m_imm = 0;

  always #10 clk = ~clk;

  acc4_core u_acc4_core (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .periph_hit(periph_hit), .bus_out(bus_out)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'hC, 4'hD, 4'hE: return "R4";
      4'h8, 4'hA:             return "R5";
      4'h9, 4'hB:             return "R6";
      4'h1:                   return "R7";
      4'h2:                   return "R8";
      4'h7:                   return "R9";
      4'h3, 4'hF:             return "R10";
      default:                return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // starts mid-T0, returns mid-T0 of the next instruction
  task automatic run(input logic [3:0] op, input logic [3:0] d, input logic hit);
    logic [3:0] src, nrr;
    logic ncy, mar, wr, jmp, nimm;
    logic [7:0] e0, e1;
    int t;
    string tg;
    tg = tag_of(op);
    src = m_imm ? d : m_rr;
    nrr = m_rr; ncy = m_cy; mar = 0; wr = 0; jmp = 0; nimm = 0;
    case (op)
      4'h0: nrr = d;
      4'h1: wr = !hit;
      4'h2: nimm = 1;
      4'h3: begin m_mab[3:0] = src; mar = 1; end
      4'h4: jmp = 1;
      4'h5: jmp = m_cy;
      4'h6: jmp = (m_rr == 0);
      4'h7: begin m_dr[m_ptr*4 +: 4] = src; m_ptr = (m_ptr + 1) % 3; nimm = m_imm; end
      4'h8: begin t = m_rr + d; nrr = t[3:0]; ncy = (t > 15); end
      4'h9: begin t = m_rr - d; nrr = t[3:0]; ncy = (t >= 0); end
      4'hA: begin t = m_rr + d + m_cy; nrr = t[3:0]; ncy = (t > 15); end
      4'hB: begin t = m_rr - d - (1 - m_cy); nrr = t[3:0]; ncy = (t >= 0); end
      4'hC: nrr = m_rr | d;
      4'hD: nrr = m_rr & d;
      4'hE: nrr = m_rr ^ d;
      default: begin m_mab[7:4] = src; mar = 1; end
    endcase
    e0 = (op == 4'h4 || op == 4'h5 || op == 4'h6) ? m_dr[7:0] : m_mab;
    e1 = {nimm, jmp, wr, mar, jmp ? m_dr[11:8] : nrr};
    m_rr = nrr; m_cy = ncy; m_imm = nimm;

    bus_in = op;
    @(negedge clk);
    bus_in = d; periph_hit = hit;
    #2 chk({tg, " DB0 (R2)"}, bus_out, e0);
    @(negedge clk);
    chk({tg, " DB1 in T2 (R3)"}, bus_out, e1);
    periph_hit = 0;
    @(negedge clk);
    chk("R2 DB1 held in T3", bus_out, e1);
    @(negedge clk);
    chk("R2 zero in T0", bus_out, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1A2B);
    repeat (3) @(negedge clk);
    chk("R1 output during reset", bus_out, 8'h00);
    rst_n = 1;
    // R1: reset state shows through a jump on zero, a store and an address load
    run(4'h6, 4'h0, 0);
    run(4'h1, 4'h0, 0);
    run(4'h3, 4'h9, 0);
    // R8/R9: immediate held over three LDRs, then wrap with the result register
    run(4'h2, 4'h0, 0);
    run(4'h7, 4'h5, 0);
    run(4'h7, 4'h3, 0);
    run(4'h7, 4'hA, 0);
    run(4'h0, 4'h6, 0);
    run(4'h7, 4'h0, 0);
    run(4'h4, 4'h0, 0);
    // R5/R11: carry out of 0xF + 1, then jump on carry and zero
    run(4'h0, 4'hF, 0);
    run(4'h8, 4'h1, 0);
    run(4'h5, 4'h0, 0);
    run(4'h6, 4'h0, 0);
    run(4'hA, 4'hF, 0);
    // R6: borrow and no borrow with both carry values
    run(4'h9, 4'h3, 0);
    run(4'hB, 4'h0, 0);
    run(4'hB, 4'h2, 0);
    run(4'h5, 4'h0, 0);
    // R4: logic ops keep the carry
    run(4'hC, 4'h5, 0);
    run(4'h5, 4'h0, 0);
    // R7: store with and without a peripheral hit
    run(4'h1, 4'h0, 1);
    run(4'h1, 4'h0, 0);
    // R10: immediate high address nibble
    run(4'h2, 4'h0, 0);
    run(4'hF, 4'hC, 0);
    for (int i = 0; i < 300; i++) begin
      logic [3:0] rop, rd;
      logic rh;
      rop = 4'($urandom);
      rd  = 4'($urandom);
      rh  = ($urandom % 4) == 0;
      run(rop, rd, rh);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule